// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit turns the addressing fields of a 16-bit instruction into a memory address. From a two-bit mode field, a three-bit register/memory field, a 16-bit displacement word and the current pointer, index and segment registers, it forms the 16-bit offset within a segment and picks the default segment, either the data segment or the stack segment. It then forms the 20-bit physical address: the segment value times sixteen plus the offset.

It handles every memory form of 16-bit addressing. These are a single pointer or index register, either of those plus a displacement, a pointer plus an index, a pointer plus an index plus a displacement, and the displacement-only direct form. The register-operand mode is reported through a flag, and the address outputs are then marked invalid. The displacement size comes only from the mode field, so no separate size input exists. A parameter adds one register stage to the outputs. By default that stage is present, and results appear one clock after their inputs.

Top module: `ea_gen`

## Requirements
- R1: The register/memory field selects the offset terms as follows: 0 = BX+SI, 1 = BX+DI, 2 = BP+SI, 3 = BP+DI, 4 = SI, 5 = DI, 6 = BP, 7 = BX.
- R2: The displacement term depends on the mode field. Mode 0 adds none. Mode 1 adds the low byte of the displacement input, sign-extended to 16 bits, and ignores the upper byte. Mode 2 adds all 16 bits.
- R3: Mode 0 with field value 6 is the direct form. The offset is then the full 16-bit displacement input, BP is not used, and the data segment is selected.
- R4: The offset is an unsigned 16-bit sum that wraps modulo 65536.
- R5: The segment select output is 1 (stack segment) for every form whose base is BP, meaning field values 2 and 3 in modes 0 to 2 and field value 6 in modes 1 and 2. For all other memory forms it is 0 (data segment).
- R6: The physical address is the selected segment value times 16 plus the offset, taken modulo 2^20.
- R7: Mode 3 sets the register flag, clears the address valid flag, and drives the offset, physical address and segment select to 0.
- R8: For modes 0 to 2 the address valid flag is 1 and the register flag is 0.
- R9: With the output stage enabled (default), results appear one clock after their inputs. While reset is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low synchronous reset |
| modeField | input | 2 | Addressing mode field |
| rmField | input | 3 | Register/memory field |
| dispIn | input | 16 | Displacement word; only the low byte is used in mode 1 |
| bxVal | input | 16 | Current BX value |
| bpVal | input | 16 | Current BP value |
| siVal | input | 16 | Current SI value |
| diVal | input | 16 | Current DI value |
| dsVal | input | 16 | Data segment value |
| ssVal | input | 16 | Stack segment value |
| effAddr | output | 16 | Effective address (offset in segment) |
| segIsStack | output | 1 | 1 = stack segment selected, 0 = data segment |
| physAddr | output | 20 | Physical address |
| addrValid | output | 1 | Address outputs are meaningful |
| isRegister | output | 1 | Register-operand mode, no memory address |

## Verification
The bench targets the direct-form exception. A design that treats it as a BP reference returns BP plus nothing, and it selects the stack segment. It drives displacement low bytes of 0x80 and 0xFF with upper bytes that disagree with the sign. A design that zero-extends, or that passes the upper byte through in mode 1, then gives the wrong offset. It forces wraparound of both the 16-bit offset sum and the 20-bit physical sum, where a design that widens its adders shows a carried-out bit. It also checks the BP-with-displacement forms, where a design that keys the segment choice on the field value alone picks the data segment.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } dispKind_e;

  typedef enum logic {
    BASE_BX = 1'b0,
    BASE_BP = 1'b1
  } baseSel_e;

  typedef enum logic {
    IDX_SI = 1'b0,
    IDX_DI = 1'b1
  } idxSel_e;

  // strobes from the decoder to the adder datapath
  typedef struct packed {
    logic      useBase;
    baseSel_e  baseSel;
    logic      useIdx;
    idxSel_e   idxSel;
    dispKind_e dispKind;
    logic      segStack;
    logic      regForm;
  } eaStrobes_t;

endpackage

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
(
  input  logic [1:0] modeField,
  input  logic [2:0] rmField,
  output eaStrobes_t strobes
);

  logic directForm;

  assign directForm = (modeField == 2'b00) && (rmField == 3'b110);

  always_comb begin
    strobes          = '0;
    strobes.baseSel  = BASE_BX;
    strobes.idxSel   = IDX_SI;
    strobes.dispKind = DISP_NONE;

    unique case (rmField)
      3'b000: begin strobes.useBase = 1'b1; strobes.baseSel = BASE_BX;
                    strobes.useIdx  = 1'b1; strobes.idxSel  = IDX_SI; end
      3'b001: begin strobes.useBase = 1'b1; strobes.baseSel = BASE_BX;
                    strobes.useIdx  = 1'b1; strobes.idxSel  = IDX_DI; end
      3'b010: begin strobes.useBase = 1'b1; strobes.baseSel = BASE_BP;
                    strobes.useIdx  = 1'b1; strobes.idxSel  = IDX_SI; end
      3'b011: begin strobes.useBase = 1'b1; strobes.baseSel = BASE_BP;
                    strobes.useIdx  = 1'b1; strobes.idxSel  = IDX_DI; end
      3'b100: begin strobes.useIdx  = 1'b1; strobes.idxSel  = IDX_SI; end
      3'b101: begin strobes.useIdx  = 1'b1; strobes.idxSel  = IDX_DI; end
      3'b110: begin strobes.useBase = !directForm; strobes.baseSel = BASE_BP; end
      default: begin strobes.useBase = 1'b1; strobes.baseSel = BASE_BX; end
    endcase

    unique case (modeField)
      2'b00:   strobes.dispKind = directForm ? DISP_WORD : DISP_NONE;
      2'b01:   strobes.dispKind = DISP_BYTE;
      2'b10:   strobes.dispKind = DISP_WORD;
      default: strobes.dispKind = DISP_NONE;
    endcase

    // stack segment whenever BP actually contributes as base
    strobes.segStack = strobes.useBase && (strobes.baseSel == BASE_BP);

    if (modeField == 2'b11) begin
      strobes          = '0;
      strobes.baseSel  = BASE_BX;
      strobes.idxSel   = IDX_SI;
      strobes.dispKind = DISP_NONE;
      strobes.regForm  = 1'b1;
    end
  end

endmodule

// File: rtl/ea_gen_datapath.sv
module ea_gen_datapath
  import ea_gen_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int BYTE_W    = 8,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  eaStrobes_t        strobes,
  input  logic [OFS_W-1:0]  dispIn,
  input  logic [OFS_W-1:0]  bxVal,
  input  logic [OFS_W-1:0]  bpVal,
  input  logic [OFS_W-1:0]  siVal,
  input  logic [OFS_W-1:0]  diVal,
  input  logic [OFS_W-1:0]  dsVal,
  input  logic [OFS_W-1:0]  ssVal,
  output logic [OFS_W-1:0]  effAddr,
  output logic              segIsStack,
  output logic [PHYS_W-1:0] physAddr,
  output logic              addrValid,
  output logic              isRegister
);

  logic [OFS_W-1:0]  baseTerm;
  logic [OFS_W-1:0]  idxTerm;
  logic [OFS_W-1:0]  dispTerm;
  logic [OFS_W-1:0]  offsetSum;
  logic [OFS_W-1:0]  segWord;
  logic [PHYS_W-1:0] segScaled;
  logic [PHYS_W-1:0] ofsWide;

  always_comb begin
    if (!strobes.useBase)                baseTerm = '0;
    else if (strobes.baseSel == BASE_BP) baseTerm = bpVal;
    else                                 baseTerm = bxVal;
  end

  always_comb begin
    if (!strobes.useIdx)                idxTerm = '0;
    else if (strobes.idxSel == IDX_DI)  idxTerm = diVal;
    else                                idxTerm = siVal;
  end

  always_comb begin
    unique case (strobes.dispKind)
      DISP_BYTE: dispTerm = {{(OFS_W-BYTE_W){dispIn[BYTE_W-1]}}, dispIn[BYTE_W-1:0]};
      DISP_WORD: dispTerm = dispIn;
      default:   dispTerm = '0;
    endcase
  end

  // modulo 2^OFS_W by width truncation
  assign offsetSum = baseTerm + idxTerm + dispTerm;

  assign segWord   = strobes.segStack ? ssVal : dsVal;
  assign segScaled = {segWord, {SEG_SHIFT{1'b0}}};
  assign ofsWide   = {{SEG_SHIFT{1'b0}}, offsetSum};

  always_comb begin
    if (strobes.regForm) begin
      effAddr    = '0;
      segIsStack = 1'b0;
      physAddr   = '0;
      addrValid  = 1'b0;
      isRegister = 1'b1;
    end else begin
      effAddr    = offsetSum;
      segIsStack = strobes.segStack;
      physAddr   = segScaled + ofsWide;
      addrValid  = 1'b1;
      isRegister = 1'b0;
    end
  end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int  OFS_W     = 16,
  parameter int  SEG_SHIFT = 4,
  parameter bit  OUT_REG   = 1'b1,
  localparam int PHYS_W    = OFS_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeField,
  input  logic [2:0]        rmField,
  input  logic [OFS_W-1:0]  dispIn,
  input  logic [OFS_W-1:0]  bxVal,
  input  logic [OFS_W-1:0]  bpVal,
  input  logic [OFS_W-1:0]  siVal,
  input  logic [OFS_W-1:0]  diVal,
  input  logic [OFS_W-1:0]  dsVal,
  input  logic [OFS_W-1:0]  ssVal,
  output logic [OFS_W-1:0]  effAddr,
  output logic              segIsStack,
  output logic [PHYS_W-1:0] physAddr,
  output logic              addrValid,
  output logic              isRegister
);

  eaStrobes_t        strobes;
  logic [OFS_W-1:0]  eaComb;
  logic              segComb;
  logic [PHYS_W-1:0] physComb;
  logic              validComb;
  logic              regComb;

  ea_gen_ctrl u_ctrl (
    .modeField (modeField),
    .rmField   (rmField),
    .strobes   (strobes)
  );

  ea_gen_datapath #(
    .OFS_W     (OFS_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_dp (
    .strobes    (strobes),
    .dispIn     (dispIn),
    .bxVal      (bxVal),
    .bpVal      (bpVal),
    .siVal      (siVal),
    .diVal      (diVal),
    .dsVal      (dsVal),
    .ssVal      (ssVal),
    .effAddr    (eaComb),
    .segIsStack (segComb),
    .physAddr   (physComb),
    .addrValid  (validComb),
    .isRegister (regComb)
  );

  generate
    if (OUT_REG) begin : g_outReg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          effAddr    <= '0;
          segIsStack <= 1'b0;
          physAddr   <= '0;
          addrValid  <= 1'b0;
          isRegister <= 1'b0;
        end else begin
          effAddr    <= eaComb;
          segIsStack <= segComb;
          physAddr   <= physComb;
          addrValid  <= validComb;
          isRegister <= regComb;
        end
      end
    end else begin : g_outComb
      assign effAddr    = eaComb;
      assign segIsStack = segComb;
      assign physAddr   = physComb;
      assign addrValid  = validComb;
      assign isRegister = regComb;
    end
  endgenerate

endmodule

// File: rtl/ea_gen_checker.sv
module ea_gen_checker #(
  parameter int  OFS_W     = 16,
  parameter int  SEG_SHIFT = 4,
  parameter bit  OUT_REG   = 1'b1,
  localparam int PHYS_W    = OFS_W + SEG_SHIFT
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeField,
  input logic [2:0]        rmField,
  input logic [OFS_W-1:0]  dispIn,
  input logic [OFS_W-1:0]  dsVal,
  input logic [OFS_W-1:0]  ssVal,
  input logic [OFS_W-1:0]  effAddr,
  input logic              segIsStack,
  input logic [PHYS_W-1:0] physAddr,
  input logic              addrValid,
  input logic              isRegister
);

  logic [1:0]       refMode;
  logic [2:0]       refRm;
  logic [OFS_W-1:0] refDisp, refDs, refSs;
  logic             armed;

  generate
    if (OUT_REG) begin : g_lag
      always_ff @(posedge clk) begin
        refMode <= modeField;
        refRm   <= rmField;
        refDisp <= dispIn;
        refDs   <= dsVal;
        refSs   <= ssVal;
        armed   <= rstN;
      end
    end else begin : g_now
      assign refMode = modeField;
      assign refRm   = rmField;
      assign refDisp = dispIn;
      assign refDs   = dsVal;
      assign refSs   = ssVal;
      assign armed   = 1'b1;
    end
  endgenerate

  assert_direct_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && refMode == 2'b00 && refRm == 3'b110) |-> (effAddr == refDisp && !segIsStack));

  assert_bp_stack_R5: assert property (@(posedge clk) disable iff (!rstN)
    (armed && refMode != 2'b11 && (refRm == 3'b010 || refRm == 3'b011 ||
     (refRm == 3'b110 && refMode != 2'b00))) |-> segIsStack);

  assert_phys_sum_R6: assert property (@(posedge clk) disable iff (!rstN)
    (armed && addrValid) |->
      physAddr == PHYS_W'({(segIsStack ? refSs : refDs), {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, effAddr}));

  assert_reg_form_R7: assert property (@(posedge clk) disable iff (!rstN)
    (armed && refMode == 2'b11) |-> (isRegister && !addrValid && effAddr == '0 && physAddr == '0));

  assert_mem_form_R8: assert property (@(posedge clk) disable iff (!rstN)
    (armed && refMode != 2'b11) |-> (addrValid && !isRegister));

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && isRegister));

endmodule

bind ea_gen ea_gen_checker #(
  .OFS_W     (OFS_W),
  .SEG_SHIFT (SEG_SHIFT),
  .OUT_REG   (OUT_REG)
) u_ea_gen_checker (
  .clk        (clk),
  .rstN       (rstN),
  .modeField  (modeField),
  .rmField    (rmField),
  .dispIn     (dispIn),
  .dsVal      (dsVal),
  .ssVal      (ssVal),
  .effAddr    (effAddr),
  .segIsStack (segIsStack),
  .physAddr   (physAddr),
  .addrValid  (addrValid),
  .isRegister (isRegister)
);

// File: tb/ea_gen_bench.sv
module ea_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeField = '0;
  logic [2:0]  rmField = '0;
  logic [15:0] dispIn = '0, bxVal = '0, bpVal = '0, siVal = '0, diVal = '0, dsVal = '0, ssVal = '0;
  logic [15:0] effAddr;
  logic        segIsStack;
  logic [19:0] physAddr;
  logic        addrValid, isRegister;

  typedef struct {
    logic [15:0] ea;
    logic        stk;
    logic [19:0] pa;
    logic        vld;
    logic        reg_;
    logic [1:0]  md;
    logic [2:0]  rm;
  } expItem_t;

  expItem_t expQ[$];
  int nVec = 0, nBad = 0;
  bit driveDone = 0;

  always #5 clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rstN(rstN), .modeField(modeField), .rmField(rmField), .dispIn(dispIn),
    .bxVal(bxVal), .bpVal(bpVal), .siVal(siVal), .diVal(diVal), .dsVal(dsVal), .ssVal(ssVal),
    .effAddr(effAddr), .segIsStack(segIsStack), .physAddr(physAddr),
    .addrValid(addrValid), .isRegister(isRegister)
  );

  // reference model, written from the requirements
  function automatic expItem_t model(logic [1:0] md, logic [2:0] rm, logic [15:0] d,
                                     logic [15:0] bx, logic [15:0] bp, logic [15:0] si,
                                     logic [15:0] di, logic [15:0] ds, logic [15:0] ss);
    expItem_t e;
    logic [15:0] sum, dv, sg;
    e.md = md; e.rm = rm;
    if (md == 2'b11) begin
      e.ea = 0; e.stk = 0; e.pa = 0; e.vld = 0; e.reg_ = 1; return e;
    end
    case (rm)                                   // R1
      3'd0: sum = bx + si;
      3'd1: sum = bx + di;
      3'd2: sum = bp + si;
      3'd3: sum = bp + di;
      3'd4: sum = si;
      3'd5: sum = di;
      3'd6: sum = (md == 2'b00) ? 16'd0 : bp;   // R3
      default: sum = bx;
    endcase
    case (md)                                   // R2
      2'b01:   dv = {{8{d[7]}}, d[7:0]};
      2'b10:   dv = d;
      default: dv = (rm == 3'd6) ? d : 16'd0;
    endcase
    e.ea  = sum + dv;                           // R4
    e.stk = (rm == 3'd2 || rm == 3'd3 || (rm == 3'd6 && md != 2'b00)); // R5
    sg    = e.stk ? ss : ds;
    e.pa  = {sg, 4'b0} + {4'b0, e.ea};          // R6
    e.vld = 1; e.reg_ = 0;                      // R8
    return e;
  endfunction

  task automatic apply(logic [1:0] md, logic [2:0] rm, logic [15:0] d,
                       logic [15:0] bx, logic [15:0] bp, logic [15:0] si,
                       logic [15:0] di, logic [15:0] ds, logic [15:0] ss);
    @(negedge clk);
    modeField = md; rmField = rm; dispIn = d;
    bxVal = bx; bpVal = bp; siVal = si; diVal = di; dsVal = ds; ssVal = ss;
    expQ.push_back(model(md, rm, d, bx, bp, si, di, ds, ss));
  endtask

  // monitor: one cycle of latency (R9)
  initial begin
    @(posedge rstN);
    forever begin
      @(posedge clk); #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        nVec++;
        if (isRegister !== e.reg_ || addrValid !== e.vld) begin
          nBad++;
          $display("FAIL R7/R8 md=%0d rm=%0d flags reg=%b vld=%b expected reg=%b vld=%b",
                   e.md, e.rm, isRegister, addrValid, e.reg_, e.vld);
        end else if (effAddr !== e.ea) begin
          nBad++;
          $display("FAIL R1/R2/R3/R4 md=%0d rm=%0d effAddr=%h expected %h", e.md, e.rm, effAddr, e.ea);
        end else if (segIsStack !== e.stk) begin
          nBad++;
          $display("FAIL R5 md=%0d rm=%0d segIsStack=%b expected %b", e.md, e.rm, segIsStack, e.stk);
        end else if (physAddr !== e.pa) begin
          nBad++;
          $display("FAIL R6 md=%0d rm=%0d physAddr=%h expected %h", e.md, e.rm, physAddr, e.pa);
        end
      end else if (driveDone) break;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    nVec++;                                           // R9 reset state
    if (effAddr !== 0 || physAddr !== 0 || addrValid !== 0 || isRegister !== 0 || segIsStack !== 0) begin
      nBad++;
      $display("FAIL R9 reset outputs ea=%h pa=%h v=%b r=%b s=%b expected all 0",
               effAddr, physAddr, addrValid, isRegister, segIsStack);
    end
    @(negedge clk); rstN = 1'b1;

    // all mode/field pairs, random register values
    for (int pass = 0; pass < 6; pass++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 8; r++)
          apply(2'(m), 3'(r), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                16'($urandom), 16'($urandom), 16'($urandom));

    // R2 sign extension edges with misleading upper bytes
    for (int r = 0; r < 8; r++) begin
      apply(2'b01, 3'(r), 16'h0080, 16'h1000, 16'h2000, 16'h0300, 16'h0040, 16'h1234, 16'h4321);
      apply(2'b01, 3'(r), 16'h00FF, 16'h1000, 16'h2000, 16'h0300, 16'h0040, 16'h1234, 16'h4321);
      apply(2'b01, 3'(r), 16'hFF7F, 16'h1000, 16'h2000, 16'h0300, 16'h0040, 16'h1234, 16'h4321);
      apply(2'b10, 3'(r), 16'h0080, 16'h1000, 16'h2000, 16'h0300, 16'h0040, 16'h1234, 16'h4321);
    end
    // R3 direct form with nonzero BP
    apply(2'b00, 3'd6, 16'h1000, 16'h1111, 16'hBEEF, 16'h2222, 16'h3333, 16'h0800, 16'h9000);
    // R5 BP forms with displacement
    apply(2'b01, 3'd6, 16'h0000, 16'h0, 16'h0100, 16'h0, 16'h0, 16'h1000, 16'h2000);
    apply(2'b10, 3'd6, 16'h1234, 16'h0, 16'h0100, 16'h0, 16'h0, 16'h1000, 16'h2000);
    // R4 offset wrap
    apply(2'b10, 3'd0, 16'hFFFF, 16'hFFFF, 16'h0, 16'h0002, 16'h0, 16'h0000, 16'h0);
    // R6 physical wrap
    apply(2'b00, 3'd7, 16'h0000, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0);
    apply(2'b01, 3'd3, 16'h00F0, 16'h0, 16'hFF00, 16'h0, 16'h00FF, 16'h0, 16'hFFFF);
    // R7 register mode with large inputs
    apply(2'b11, 3'd6, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);

    driveDone = 1;
    repeat (4) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule